// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

An up-counting timer with one compare channel that shapes a single waveform output. The counter advances on an enable tick and returns to zero (BOTTOM) after reaching its TOP value. The TOP value is either all ones or the compare value, depending on the waveform mode. A 2-bit compare action field and the waveform mode together decide what the output level does on a compare match and on the return to BOTTOM. This gives plain toggle, set or clear behaviour in the non-PWM modes, and non-inverting or inverting pulse-width modulation in fast PWM mode.

The block also produces an output-drive enable that tells the pad logic when the waveform replaces normal port use. It produces single-cycle match and overflow flags as well. Prescaling, interrupt logic and register access sit outside the block.

Top module: `wavegen_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the output level, `match_flag` and `ovf_flag` are 0 and the count is 0.
- R2: The count changes only on a cycle with `tick` high. On such a cycle it goes to 0 if it equals TOP and otherwise adds one. `ovf_flag` is high for exactly the one cycle after the clock edge that took the count from TOP to 0.
- R3: `wave_mode` encodes 00 normal, 01 clear-timer-on-compare, 10 fast PWM and 11 treated as normal. TOP is all ones in normal mode, and in fast PWM when `top_sel` is 0. TOP is `cmp_val` in clear-timer-on-compare mode, and in fast PWM when `top_sel` is 1.
- R4: `match_flag` is high for the one cycle after an edge where `tick` was high and the count equalled `cmp_val`. This holds even when the output action is suppressed.
- R5: In modes 00, 01 and 11, `cmp_mode` 01 inverts the level on a match, 10 drives it to 0 and 11 drives it to 1. The new level appears at the same edge that raises `match_flag`.
- R6: In fast PWM, `cmp_mode` 01 leaves the level untouched when `top_sel` is 0. When `top_sel` is 1, it inverts the level on each match.
- R7: In fast PWM, `cmp_mode` 10 drives the level to 0 on a match and to 1 when the count wraps to BOTTOM.
- R8: In fast PWM, `cmp_mode` 11 drives the level to 1 on a match and to 0 when the count wraps to BOTTOM.
- R9: In fast PWM with `cmp_mode[1]` set and `cmp_val` equal to TOP, the match has no effect on the level. Only the BOTTOM action of R7 or R8 takes place.
- R10: `out_en` is high exactly when `dir_en` is 1, `cmp_mode` is not 00, and the pair (fast PWM, `cmp_mode` 01, `top_sel` 0) does not hold. It follows its inputs in the same cycle.
- R11: With `cmp_mode` 00, the level keeps its value through matches and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| cmp_val | input | CNT_W | Compare value |
| cmp_mode | input | 2 | Compare output action field |
| wave_mode | input | 2 | Waveform mode select |
| top_sel | input | 1 | In fast PWM, selects compare value as TOP |
| dir_en | input | 1 | Port direction bit gating the drive enable |
| wave_out | output | 1 | Waveform level |
| out_en | output | 1 | Waveform takes over the pin |
| match_flag | output | 1 | One-cycle compare match pulse |
| ovf_flag | output | 1 | One-cycle TOP-to-BOTTOM pulse |

## Verification
The count itself is never visible, so a corrupted count or a wrong TOP choice first shows as a misplaced `ovf_flag` or `match_flag` pulse. In the worst case this takes one full period of up to 256 ticks. A wrong level register shows on `wave_out` at the next match or wrap, and a wrong action decode shows at the first event in the affected mode. The sweep covers every mode, field and top-select combination with compare values at 0, small, mid and all ones. It compares all four outputs on every cycle, so a fault surfaces within one period of its cause.

// File: rtl/wg_pkg.sv
package wg_pkg;

   typedef enum logic [1:0] {
      WM_NORMAL = 2'b00,
      WM_CTC    = 2'b01,
      WM_FAST   = 2'b10,
      WM_RSVD   = 2'b11
   } wmode_e;

   typedef enum logic [1:0] {
      CO_OFF    = 2'b00,
      CO_TOGGLE = 2'b01,
      CO_CLEAR  = 2'b10,
      CO_SET    = 2'b11
   } cmode_e;

   typedef struct packed {
      logic hit;
      logic wrap;
      logic suppress;
      logic fast;
   } evt_t;

endpackage

// File: rtl/wg_counter.sv
module wg_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             ovf_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign wrap = tick && (cnt == top);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= wrap;
         if (tick) begin
            cnt <= wrap ? '0 : cnt + ONE;
         end
      end
   end

endmodule

// File: rtl/wg_compare.sv
module wg_compare
   import wg_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [1:0]       cmp_mode,
   input  logic [1:0]       wave_mode,
   input  logic             top_sel,
   output logic [CNT_W-1:0] top,
   output logic             hit,
   output logic             suppress,
   output logic             fast,
   output logic             match_q
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic top_from_cmp;

   assign fast         = (wmode_e'(wave_mode) == WM_FAST);
   assign top_from_cmp = (wmode_e'(wave_mode) == WM_CTC) || (fast && top_sel);
   assign top          = top_from_cmp ? cmp_val : ALL_ONES;
   assign hit          = tick && (cnt == cmp_val);
   assign suppress     = fast && cmp_mode[1] && (cmp_val == top);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= 1'b0;
      end else begin
         match_q <= hit;
      end
   end

endmodule

// File: rtl/wg_outctl.sv
module wg_outctl
   import wg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  evt_t       evt,
   input  logic [1:0] cmp_mode,
   input  logic       top_sel,
   input  logic       dir_en,
   output logic       level,
   output logic       drive_en
);

   logic   lvl_nxt;
   logic   connected;
   cmode_e act;

   assign act       = cmode_e'(cmp_mode);
   assign connected = (act != CO_OFF) && !(evt.fast && act == CO_TOGGLE && !top_sel);
   assign drive_en  = connected && dir_en;

   always_comb begin
      lvl_nxt = level;
      if (evt.fast) begin
         unique case (act)
            CO_TOGGLE: if (evt.hit && top_sel) lvl_nxt = ~level;
            CO_CLEAR: begin
               if (evt.hit && !evt.suppress) lvl_nxt = 1'b0;
               if (evt.wrap)                 lvl_nxt = 1'b1;
            end
            CO_SET: begin
               if (evt.hit && !evt.suppress) lvl_nxt = 1'b1;
               if (evt.wrap)                 lvl_nxt = 1'b0;
            end
            default: lvl_nxt = level;
         endcase
      end else begin
         unique case (act)
            CO_TOGGLE: if (evt.hit) lvl_nxt = ~level;
            CO_CLEAR:  if (evt.hit) lvl_nxt = 1'b0;
            CO_SET:    if (evt.hit) lvl_nxt = 1'b1;
            default:   lvl_nxt = level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= 1'b0;
      end else begin
         level <= lvl_nxt;
      end
   end

endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
   import wg_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [1:0]       cmp_mode,
   input  logic [1:0]       wave_mode,
   input  logic             top_sel,
   input  logic             dir_en,
   output logic             wave_out,
   output logic             out_en,
   output logic             match_flag,
   output logic             ovf_flag
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("wavegen_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] top;
   logic             wrap;
   logic             hit;
   logic             suppress;
   logic             fast;
   evt_t             evt;

   wg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .top   (top),
      .cnt   (cnt),
      .wrap  (wrap),
      .ovf_q (ovf_flag)
   );

   wg_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt       (cnt),
      .cmp_val   (cmp_val),
      .cmp_mode  (cmp_mode),
      .wave_mode (wave_mode),
      .top_sel   (top_sel),
      .top       (top),
      .hit       (hit),
      .suppress  (suppress),
      .fast      (fast),
      .match_q   (match_flag)
   );

   assign evt = '{hit: hit, wrap: wrap, suppress: suppress, fast: fast};

   wg_outctl u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .cmp_mode (cmp_mode),
      .top_sel  (top_sel),
      .dir_en   (dir_en),
      .level    (wave_out),
      .drive_en (out_en)
   );

endmodule

// File: rtl/wavegen_timer_chk.sv
module wavegen_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic [1:0] cmp_mode,
   input logic [1:0] wave_mode,
   input logic       dir_en,
   input logic       wave_out,
   input logic       out_en,
   input logic       match_flag,
   input logic       ovf_flag
);

   // R2
   ovf_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |-> $past(tick));

   // R4
   match_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_flag |-> $past(tick));

   // R11
   off_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmp_mode) == 2'b00) |-> $stable(wave_out));

   // R5
   plain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && $past(wave_mode) != 2'b10 && $past(cmp_mode) == 2'b10) |-> !wave_out);

   // R7
   pwm_noninv_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && $past(wave_mode) == 2'b10 && $past(cmp_mode) == 2'b10) |-> wave_out);

   // R8
   pwm_inv_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && $past(wave_mode) == 2'b10 && $past(cmp_mode) == 2'b11) |-> !wave_out);

   // R10
   dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_en || cmp_mode == 2'b00) |-> !out_en);

endmodule

bind wavegen_timer wavegen_timer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .cmp_mode   (cmp_mode),
   .wave_mode  (wave_mode),
   .dir_en     (dir_en),
   .wave_out   (wave_out),
   .out_en     (out_en),
   .match_flag (match_flag),
   .ovf_flag   (ovf_flag)
);

// File: tb/wavegen_timer_tb.sv
`timescale 1ns/1ps
module wavegen_timer_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [W-1:0] cmp_val = '0;
   logic [1:0]   cmp_mode = 2'b00;
   logic [1:0]   wave_mode = 2'b00;
   logic         top_sel = 1'b0;
   logic         dir_en = 1'b0;
   logic         wave_out, out_en, match_flag, ovf_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference state
   int  m_cnt;
   bit  m_lvl, m_match, m_ovf;

   always #10 clk = ~clk;

   wavegen_timer #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_val(cmp_val),
      .cmp_mode(cmp_mode), .wave_mode(wave_mode), .top_sel(top_sel),
      .dir_en(dir_en), .wave_out(wave_out), .out_en(out_en),
      .match_flag(match_flag), .ovf_flag(ovf_flag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (wm=%0d cm=%0d ts=%0d cv=%0d t=%0t)",
                  req, act, exp, wave_mode, cmp_mode, top_sel, cmp_val, $time);
      end
   endtask

   function automatic bit exp_en();
      bit conn;
      conn = (cmp_mode != 2'b00) && !(wave_mode == 2'b10 && cmp_mode == 2'b01 && !top_sel);
      return conn && dir_en;
   endfunction

   function automatic string lvl_tag();
      int top;
      top = (wave_mode == 2'b01 || (wave_mode == 2'b10 && top_sel)) ? int'(cmp_val) : 255;
      if (cmp_mode == 2'b00) return "R11";
      if (wave_mode != 2'b10) return "R5";
      if (cmp_mode == 2'b01) return "R6";
      if (int'(cmp_val) == top) return "R9";
      if (cmp_mode == 2'b10) return "R7";
      return "R8";
   endfunction

   // model one clock edge using the inputs currently applied
   task automatic model_edge();
      int  top;
      bit  wr, mt, fast, supp;
      fast = (wave_mode == 2'b10);
      top  = (wave_mode == 2'b01 || (fast && top_sel)) ? int'(cmp_val) : 255;
      wr   = tick && (m_cnt == top);
      mt   = tick && (m_cnt == int'(cmp_val));
      supp = fast && cmp_mode[1] && (int'(cmp_val) == top);
      if (tick) m_cnt = wr ? 0 : (m_cnt + 1) % 256;
      m_ovf   = wr;
      m_match = mt;
      if (fast) begin
         case (cmp_mode)
            2'b01: if (mt && top_sel) m_lvl = !m_lvl;
            2'b10: begin if (mt && !supp) m_lvl = 0; if (wr) m_lvl = 1; end
            2'b11: begin if (mt && !supp) m_lvl = 1; if (wr) m_lvl = 0; end
            default: ;
         endcase
      end else begin
         case (cmp_mode)
            2'b01: if (mt) m_lvl = !m_lvl;
            2'b10: if (mt) m_lvl = 0;
            2'b11: if (mt) m_lvl = 1;
            default: ;
         endcase
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick  = 1'b0;
      m_cnt = 0; m_lvl = 0; m_match = 0; m_ovf = 0;
      repeat (2) @(negedge clk);
      // R1: outputs cleared under reset
      chk("R1 level", wave_out, 1'b0);
      chk("R1 match", match_flag, 1'b0);
      chk("R1 ovf", ovf_flag, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic run_cfg(input logic [1:0] wm, input logic [1:0] cm,
                          input logic ts, input logic [W-1:0] cv, input int cycles);
      wave_mode = wm; cmp_mode = cm; top_sel = ts; cmp_val = cv;
      do_reset();
      for (int c = 0; c < cycles; c++) begin
         tick   = (c % 7) != 3;
         dir_en = (c % 5) != 0;
         #1;
         chk("R10 out_en", out_en, exp_en());
         model_edge();
         @(posedge clk);
         @(negedge clk);
         chk("R2 R3 ovf", ovf_flag, m_ovf);
         chk("R4 match", match_flag, m_match);
         chk(lvl_tag(), wave_out, m_lvl);
      end
   endtask

   initial begin
      logic [W-1:0] cvs [4];
      cvs[0] = 8'd0; cvs[1] = 8'd3; cvs[2] = 8'h80; cvs[3] = 8'hFF;
      for (int wm = 0; wm < 4; wm++)
         for (int cm = 0; cm < 4; cm++)
            for (int ts = 0; ts < 2; ts++)
               for (int k = 0; k < 4; k++)
                  run_cfg(2'(wm), 2'(cm), 1'(ts), cvs[k], (wm == 3) ? 320 : 620);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20ns * 190000);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule